// File: doc/BRIEF.md
# Stop-State On-Demand Oscillator Gate

This block manages one internal oscillator while the chip sits in a deep stop state. In that state the whole core domain is clock-gated and the oscillator is off. A few receiver peripherals are able to wake the system, for example I2C, USART or low-power UART receivers. Such a receiver may raise a request line when it detects an incoming frame. The gate then turns the oscillator on and sends the clock only to the receivers that asked for it. The rest of the core domain never sees this clock.

When a receiver reports that its frame is complete, it also reports whether the frame met its wake criteria. If it did not, that receiver loses its clock, and the oscillator is turned off once nobody else needs it. The system stays stopped throughout. If the frame did meet the wake criteria, the block raises a wake request and keeps the oscillator running until the system has left the stop state. Outside the stop state the block is transparent: the oscillator is on and every peripheral clock enable is high.

All outputs are registered and change one clock after the inputs that cause them. The control clock is an always-on low-rate clock.

Top module: `stopOscGate`

## Requirements
- R1: During and directly after reset, oscEnable is 1, every periphClkEn bit is 1 and wakeReq is 0.
- R2: When stopMode was 0 at a clock edge, after that edge oscEnable is 1, all periphClkEn bits are 1 and wakeReq is 0, whatever the requests and frame flags are.
- R3: In stop, when no peripheral holds a grant and no wake is pending, oscEnable and all periphClkEn bits are 0 one cycle later.
- R4: Bit i of the WAKE_MASK parameter (default 4'b1011) marks peripheral i as wake-capable. A peripheral whose mask bit is 0 never receives a grant in stop, so its periphClkEn bit stays 0.
- R5: In stop, a capable peripheral i gets a grant at an edge where periphReq[i] is 1, it is not blocked, and it shows no non-wake frame end. oscEnable is 1 after that edge.
- R6: In stop, periphClkEn[i] is 1 after an edge only if peripheral i holds a grant after that edge and oscReady was 1 at that edge.
- R7: With several grants held, oscEnable stays 1 until the last grant is released.
- R8: frameDone[i]=1 with wakeMatch[i]=0 on a granted peripheral, or periphReq[i] falling to 0, ends its grant at that edge. Its clock enable then drops, and oscEnable drops when no grant or wake remains.
- R9: After a non-wake frame end, peripheral i is blocked until periphReq[i] has been 0 at an edge. While blocked, its request does not turn the oscillator on.
- R10: frameDone[i]=1 with wakeMatch[i]=1 on a granted peripheral in stop sets wakeReq after that edge. wakeReq and oscEnable then stay 1 until an edge with stopMode=0.
- R11: In stop, frameDone on a peripheral with no grant does not raise wakeReq or oscEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopMode | input | 1 | 1 while the system is in the deep stop state |
| periphReq | input | NUM_PERIPH | Per-peripheral oscillator request |
| frameDone | input | NUM_PERIPH | One-cycle frame-complete pulse per peripheral |
| wakeMatch | input | NUM_PERIPH | Qualifies frameDone: frame meets wake criteria |
| oscReady | input | 1 | Oscillator output is stable |
| oscEnable | output | 1 | Oscillator enable |
| periphClkEn | output | NUM_PERIPH | Per-peripheral clock enable, bit i for peripheral i |
| wakeReq | output | 1 | System wake request |

## Verification
The bench goes after four cases in particular.
- A request that is still held after a non-wake frame end. A design that re-grants it at once would keep the oscillator burning for the whole stopped period.
- A clock enable before oscReady. A design that gets this wrong would hand a receiver a runt first pulse.
- A non-capable peripheral requesting in stop. A design that gets this wrong would clock logic that should stay dead.
- Overlapping requesters where one finishes early. A design that gets this wrong would kill the oscillator under a receiver still mid-frame.

The bench also checks that a wake frame holds the oscillator until stop is left, and that frame flags from ungranted peripherals are ignored.

// File: rtl/stopOscGatePkg.sv
package stopOscGatePkg;
  localparam int unsigned DEF_NUM_PERIPH = 4;
  localparam logic [DEF_NUM_PERIPH-1:0] DEF_WAKE_MASK = 4'b1011;
endpackage

// File: rtl/oscGateCtrl.sv
module oscGateCtrl #(
  parameter int unsigned NUM_PERIPH = 4,
  parameter logic [NUM_PERIPH-1:0] WAKE_MASK = '1,
  parameter type strobeT = logic
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stopMode,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] frameDone,
  input  logic [NUM_PERIPH-1:0] wakeMatch,
  input  logic [NUM_PERIPH-1:0] grantVec,
  output strobeT                strobes
);
  logic [NUM_PERIPH-1:0] blocked, blockedNext, idleEnd, wakeEnd;
  logic wakeLatch, wakeHit;

  always_comb begin
    idleEnd = frameDone & ~wakeMatch;
    wakeEnd = frameDone & wakeMatch & grantVec;
    wakeHit = stopMode & (|wakeEnd);
    blockedNext = {NUM_PERIPH{stopMode}} & periphReq & (blocked | idleEnd);
    strobes.setMask = {NUM_PERIPH{stopMode}} & WAKE_MASK & periphReq & ~blocked & ~idleEnd;
    strobes.clrMask = {NUM_PERIPH{~stopMode}} | idleEnd | ~periphReq;
    strobes.runMode = ~stopMode;
    strobes.keepOsc = stopMode & (wakeLatch | wakeHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blocked   <= '0;
      wakeLatch <= 1'b0;
    end else begin
      blocked   <= blockedNext;
      wakeLatch <= stopMode & (wakeLatch | wakeHit);
    end
  end
endmodule

// File: rtl/oscGateDp.sv
module oscGateDp #(
  parameter int unsigned NUM_PERIPH = 4,
  parameter type strobeT = logic
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strobes,
  input  logic                  oscReady,
  output logic [NUM_PERIPH-1:0] grantVec,
  output logic                  oscEnable,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  wakeReq
);
  logic [NUM_PERIPH-1:0] grantNext;

  always_comb grantNext = strobes.setMask | (grantVec & ~strobes.clrMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec  <= '0;
      oscEnable <= 1'b1;
      wakeReq   <= 1'b0;
    end else begin
      grantVec  <= grantNext;
      oscEnable <= strobes.runMode | (|grantNext) | strobes.keepOsc;
      wakeReq   <= strobes.keepOsc;
    end
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : gClkEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) periphClkEn[i] <= 1'b1;
      else       periphClkEn[i] <= strobes.runMode | (grantNext[i] & oscReady);
    end
  end
endmodule

// File: rtl/stopOscGate.sv
module stopOscGate
  import stopOscGatePkg::*;
#(
  parameter int unsigned NUM_PERIPH = DEF_NUM_PERIPH,
  parameter logic [NUM_PERIPH-1:0] WAKE_MASK = DEF_WAKE_MASK
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stopMode,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] frameDone,
  input  logic [NUM_PERIPH-1:0] wakeMatch,
  input  logic                  oscReady,
  output logic                  oscEnable,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  wakeReq
);
  typedef struct packed {
    logic [NUM_PERIPH-1:0] setMask;
    logic [NUM_PERIPH-1:0] clrMask;
    logic                  runMode;
    logic                  keepOsc;
  } gateStrobeT;

  gateStrobeT strobes;
  logic [NUM_PERIPH-1:0] grantVec;

  oscGateCtrl #(.NUM_PERIPH(NUM_PERIPH), .WAKE_MASK(WAKE_MASK), .strobeT(gateStrobeT)) uCtrl (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .periphReq(periphReq),
    .frameDone(frameDone), .wakeMatch(wakeMatch), .grantVec(grantVec), .strobes(strobes)
  );

  oscGateDp #(.NUM_PERIPH(NUM_PERIPH), .strobeT(gateStrobeT)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .oscReady(oscReady),
    .grantVec(grantVec), .oscEnable(oscEnable), .periphClkEn(periphClkEn), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/stopOscGateChecker.sv
module stopOscGateChecker #(
  parameter int unsigned NUM_PERIPH = 4,
  parameter logic [NUM_PERIPH-1:0] WAKE_MASK = '1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stopMode,
  input logic                  oscReady,
  input logic                  oscEnable,
  input logic [NUM_PERIPH-1:0] periphClkEn,
  input logic                  wakeReq
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  run_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(stopMode)) |-> (oscEnable && (&periphClkEn) && !wakeReq));

  // R4
  non_capable_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stopMode)) |-> ((periphClkEn & ~WAKE_MASK) == '0));

  // R6
  clk_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stopMode) && !$past(oscReady)) |-> (periphClkEn == '0));

  // R6
  clk_needs_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periphClkEn != '0) |-> oscEnable);

  // R10
  wake_holds_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> oscEnable);

  // R10
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && stopMode) |=> wakeReq);
endmodule

bind stopOscGate stopOscGateChecker #(.NUM_PERIPH(NUM_PERIPH), .WAKE_MASK(WAKE_MASK)) uChecker (
  .clk(clk), .rstN(rstN), .stopMode(stopMode), .oscReady(oscReady),
  .oscEnable(oscEnable), .periphClkEn(periphClkEn), .wakeReq(wakeReq)
);

// File: tb/tb_stopOscGate.sv
module tb_stopOscGate;
  localparam int unsigned N = 4;
  localparam logic [N-1:0] MASK = 4'b1011;
  localparam int unsigned READY_LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopMode = 1'b0;
  logic [N-1:0] periphReq = '0, frameDone = '0, wakeMatch = '0;
  logic oscReady = 1'b0;
  logic oscEnable, wakeReq;
  logic [N-1:0] periphClkEn;

  int checks = 0, failures = 0;
  logic done = 1'b0;
  logic [READY_LAT-1:0] readyPipe = '0;

  // bench model state, derived from the requirements
  logic [N-1:0] mGrant = '0, mBlk = '0, mClk = '1;
  logic mWake = 1'b0, mOsc = 1'b1;

  always #4ns clk = ~clk;

  stopOscGate #(.NUM_PERIPH(N), .WAKE_MASK(MASK)) dut (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .periphReq(periphReq),
    .frameDone(frameDone), .wakeMatch(wakeMatch), .oscReady(oscReady),
    .oscEnable(oscEnable), .periphClkEn(periphClkEn), .wakeReq(wakeReq)
  );

  function automatic logic [N-1:0] nextGrant(logic stop, logic [N-1:0] req, logic [N-1:0] fd,
                                             logic [N-1:0] wm, logic [N-1:0] g, logic [N-1:0] b);
    logic [N-1:0] idle = fd & ~wm;
    if (!stop) return '0;
    return MASK & req & ~idle & (~b | g);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mGrant <= '0; mBlk <= '0; mWake <= 1'b0; mOsc <= 1'b1; mClk <= '1;
    end else begin
      logic [N-1:0] ng;
      logic nw;
      ng = nextGrant(stopMode, periphReq, frameDone, wakeMatch, mGrant, mBlk);
      nw = stopMode & (mWake | (|(frameDone & wakeMatch & mGrant)));
      mGrant <= ng;
      mBlk   <= {N{stopMode}} & periphReq & (mBlk | (frameDone & ~wakeMatch));
      mWake  <= nw;
      mOsc   <= !stopMode || (|ng) || nw;
      mClk   <= stopMode ? (ng & {N{oscReady}}) : '1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    readyPipe = oscEnable ? {readyPipe[READY_LAT-2:0], 1'b1} : '0;
    oscReady  = readyPipe[READY_LAT-1];
    chk("R5/R7/R8 oscEnable", 32'(oscEnable), 32'(mOsc));
    chk("R6 periphClkEn", 32'(periphClkEn), 32'(mClk));
    chk("R10/R11 wakeReq", 32'(wakeReq), 32'(mWake));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oscEnable", 32'(oscEnable), 1);
    chk("R1 periphClkEn", 32'(periphClkEn), 32'hF);
    chk("R1 wakeReq", 32'(wakeReq), 0);
    rstN = 1'b1;
    tick();
    chk("R1 after release", 32'(periphClkEn), 32'hF);

    // R3 enter stop idle
    stopMode = 1'b1; tick(); tick();
    chk("R3 osc off", 32'(oscEnable), 0);
    chk("R3 clk off", 32'(periphClkEn), 0);

    // R5 / R6 single requester
    periphReq = 4'b0001; tick();
    chk("R5 osc on", 32'(oscEnable), 1);
    chk("R6 no clk before ready", 32'(periphClkEn), 0);
    repeat (4) tick();
    chk("R6 clk after ready", 32'(periphClkEn), 32'h1);

    // R4 non-capable requester
    periphReq = 4'b0101; tick(); tick();
    chk("R4 bit2 dark", 32'(periphClkEn), 32'h1);

    // R7 second capable requester
    periphReq = 4'b0011; tick();
    chk("R7 both clocked", 32'(periphClkEn), 32'h3);

    // R8 non-wake end on bit0, request held -> R9 blocked
    frameDone = 4'b0001; tick(); frameDone = '0;
    chk("R8 bit0 dropped", 32'(periphClkEn), 32'h2);
    chk("R7 osc kept", 32'(oscEnable), 1);
    tick(); tick();
    chk("R9 held request not regranted", 32'(periphClkEn), 32'h2);

    // R8 bit1 releases request: last grant gone
    periphReq = 4'b0001; tick();
    chk("R8 osc off", 32'(oscEnable), 0);
    chk("R9 still blocked", 32'(periphClkEn), 0);

    // R9 release then re-request
    periphReq = 4'b0000; tick();
    periphReq = 4'b0001; tick();
    chk("R9 regrant after release", 32'(oscEnable), 1);

    // R11 frame on ungranted peripheral
    frameDone = 4'b1000; wakeMatch = 4'b1000; tick();
    frameDone = '0; wakeMatch = '0;
    chk("R11 no wake", 32'(wakeReq), 0);

    // R10 wake frame
    repeat (4) tick();
    frameDone = 4'b0001; wakeMatch = 4'b0001; tick();
    frameDone = '0; wakeMatch = '0;
    chk("R10 wake raised", 32'(wakeReq), 1);
    periphReq = '0; repeat (3) tick();
    chk("R10 osc held", 32'(oscEnable), 1);
    chk("R10 wake held", 32'(wakeReq), 1);

    // R2 leave stop
    stopMode = 1'b0; periphReq = 4'b0110; tick();
    chk("R2 osc", 32'(oscEnable), 1);
    chk("R2 clocks", 32'(periphClkEn), 32'hF);
    chk("R2 wake cleared", 32'(wakeReq), 0);

    // constrained random
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom_range(99) < 2) stopMode = ~stopMode;
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(99) < 8) periphReq[i] = ~periphReq[i];
        frameDone[i] = periphReq[i] && ($urandom_range(99) < 6);
        wakeMatch[i] = $urandom_range(99) < 15;
      end
      tick();
    end
    frameDone = '0; wakeMatch = '0;
    tick();
    finishRun();
  end
endmodule